// File: doc/BRIEF.md
# Split Timer/Counter with Capture

This block is a 16-bit count register that can be run as one wide timer or as two 8-bit halves. A two-bit mode field picks how the halves are fed. Each half can advance on ticks from a shared reloadable prescaler or on rising edges of an external event input. A match register per half closes the count period. On the increment that would move a half past its match value, that half returns to zero and raises its interrupt flag. In the wide modes the two match registers form one 16-bit compare value, and only the high flag is used.

Two external inputs pass through a two-flop synchronizer and an edge detector. A rising edge on input A latches the low count into its capture register. A rising edge on input B latches the high count. In the wide modes, input A latches all 16 bits. Input B also serves as the event source for any half set to count events. Software sets up and observes the block through a small register port: synchronous writes and combinational reads.

The mode field is the block's state. It has four named values:
- MODE_DUAL_TMR: both halves are timers.
- MODE_TMR_EVT: low timer, high event counter.
- MODE_WIDE_TMR: 16-bit timer.
- MODE_WIDE_EVT: 16-bit event counter.

Writing the control register is the only transition. It moves from any mode to any mode, and it takes effect at the edge that performs the write.

Top module: `split_timer`

## Requirements
- R1: After reset the mode is MODE_DUAL_TMR (code 0), run is off, and every register is zero: prescaler reload, both match values, both counts, both captures and both flags.
- R2: With prescaler reload value P, a prescaled half advances once every P+1 clock cycles while run is set. The first advance comes P+1 edges after the edge that sets run.
- R3: When a half advances while its count equals its match value, it becomes zero on that edge and sets its flag on the same edge. A match value of all ones gives plain overflow. A half otherwise steps by exactly one.
- R4: Mode code 0: both halves are independent 8-bit timers driven by the same prescaler ticks. Each half is compared with its own match value.
- R5: Mode code 1: the low half is a prescaled timer, and the high half counts rising edges of input B.
- R6: Mode code 2: the halves form one 16-bit prescaled timer compared against {match_hi, match_lo}. Only the high flag is ever set.
- R7: Mode code 3: the halves form one 16-bit counter of rising edges of input B. The prescaler setting has no effect.
- R8: Each pin rise reaches its capture register on the third clock edge after the first edge that samples the pin high. The stored value is the count held in the cycle before that edge. Input A captures the low half and input B captures the high half in codes 0 and 1. In codes 2 and 3, input A captures all 16 bits and input B leaves both capture registers unchanged.
- R9: An input pulse that is one clock high followed by one clock low is counted as one event, and back-to-back such pulses are each counted.
- R10: Register addresses are 0 control, 1 prescaler reload, 2 match low, 3 match high, 4 count low, 5 count high, 6 capture low and 7 capture high.
  - Control write bits: [1:0] mode, [2] run. A 1 in bit 6 clears the low flag and a 1 in bit 7 clears the high flag.
  - Control read returns {flag_hi, flag_lo, 000, run, mode}.
  - Reads have no side effects.
- R11: While run is clear, both counts hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | HALF_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | HALF_W | Register read data (combinational) |
| cap_lo_pin | input | 1 | Input A: low (or wide) capture trigger |
| cap_hi_pin | input | 1 | Input B: high capture trigger and event source |
| irq_lo | output | 1 | Low-half interrupt flag |
| irq_hi | output | 1 | High-half (or wide) interrupt flag |

## Verification
The assertions check the following on every cycle:
- A stopped counter never moves.
- The low half only steps by one or returns to zero.
- A capture register changes only right after an edge from the input that the mode assigns to it.
- The low flag never rises in a wide mode.
- A newly raised high flag coincides with a zeroed high count.
- In the wide event mode the count moves only after an input-B edge.

Only the bench scenarios can show the exact values: the count after a given number of prescaled cycles, the period closed by each match setting, the value latched at a known pin time, and the clearing of flags through the control register.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

    typedef enum logic [1:0] {
        MODE_DUAL_TMR = 2'd0,
        MODE_TMR_EVT  = 2'd1,
        MODE_WIDE_TMR = 2'd2,
        MODE_WIDE_EVT = 2'd3
    } tmr_mode_e;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_PRESC = 3'd1;
    localparam logic [ADDR_W-1:0] A_MLO   = 3'd2;
    localparam logic [ADDR_W-1:0] A_MHI   = 3'd3;
    localparam logic [ADDR_W-1:0] A_CLO   = 3'd4;
    localparam logic [ADDR_W-1:0] A_CHI   = 3'd5;
    localparam logic [ADDR_W-1:0] A_PLO   = 3'd6;
    localparam logic [ADDR_W-1:0] A_PHI   = 3'd7;

    typedef struct packed {
        logic       clr_hi;
        logic       clr_lo;
        logic [2:0] spare;
        logic       run;
        tmr_mode_e  mode;
    } ctrl_wr_t;

endpackage

// File: rtl/split_timer_presc.sv
module split_timer_presc #(
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] reload,
    output logic             tick
);

    logic [PRE_W-1:0] pcnt_q;

    // Down-counter: held at the reload value while stopped, reloads after reaching zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (!run || pcnt_q == '0) begin
            pcnt_q <= reload;
        end else begin
            pcnt_q <= pcnt_q - PRE_W'(1);
        end
    end

    assign tick = run && (pcnt_q == '0);

endmodule

// File: rtl/split_timer_edge.sv
module split_timer_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    logic [2:0] sh_q;

    // Two synchronizing stages followed by one history stage for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[1:0], pin};
        end
    end

    assign rise = sh_q[1] & ~sh_q[2];

endmodule

// File: rtl/split_timer.sv
module split_timer
    import split_timer_pkg::*;
#(
    parameter int unsigned HALF_W = 8,
    parameter int unsigned PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [HALF_W-1:0] rd_data,
    input  logic              cap_lo_pin,
    input  logic              cap_hi_pin,
    output logic              irq_lo,
    output logic              irq_hi
);

    localparam int unsigned WIDE_W = 2 * HALF_W;
    localparam int unsigned NPINS  = 2;

    tmr_mode_e         mode_q;
    logic              run_q;
    logic [PRE_W-1:0]  presc_q;
    logic [HALF_W-1:0] mlo_q, mhi_q;
    logic [HALF_W-1:0] cnt_lo, cnt_hi;
    logic [HALF_W-1:0] cap_lo, cap_hi;
    logic              irq_lo_q, irq_hi_q;

    logic              tick;
    logic [NPINS-1:0]  pins, rises;
    logic              rise_a, rise_b;

    logic              wide, inc_lo, inc_hi, hit_lo, hit_hi;
    logic              cap_lo_en, cap_hi_en;
    logic [HALF_W-1:0] nxt_lo, nxt_hi;
    logic [WIDE_W-1:0] wide_plus;
    ctrl_wr_t          ctrl_w;
    logic              unused_wr;

    assign ctrl_w    = ctrl_wr_t'(wr_data[7:0]);
    assign unused_wr = ^wr_data;

    split_timer_presc #(.PRE_W(PRE_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .reload (presc_q),
        .tick   (tick)
    );

    assign pins = {cap_hi_pin, cap_lo_pin};

    for (genvar g = 0; g < NPINS; g++) begin : g_sync
        split_timer_edge u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pins[g]),
            .rise  (rises[g])
        );
    end

    assign rise_a = rises[0];
    assign rise_b = rises[1];

    // State register: mode and run, changed only by a control write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_DUAL_TMR;
            run_q  <= 1'b0;
        end else if (wr_en && wr_addr == A_CTRL) begin
            mode_q <= ctrl_w.mode;
            run_q  <= ctrl_w.run;
        end
    end

    // Output logic: what each half does in the current mode.
    always_comb begin
        wide   = 1'b0;
        inc_lo = 1'b0;
        inc_hi = 1'b0;
        unique case (mode_q)
            MODE_DUAL_TMR: begin inc_lo = tick;   inc_hi = tick;   end
            MODE_TMR_EVT:  begin inc_lo = tick;   inc_hi = rise_b; end
            MODE_WIDE_TMR: begin inc_lo = tick;   wide   = 1'b1;   end
            MODE_WIDE_EVT: begin inc_lo = rise_b; wide   = 1'b1;   end
        endcase
        inc_lo    = inc_lo & run_q;
        inc_hi    = inc_hi & run_q;
        wide_plus = {cnt_hi, cnt_lo} + WIDE_W'(1);
        hit_lo    = inc_lo && !wide && (cnt_lo == mlo_q);
        hit_hi    = wide ? (inc_lo && ({cnt_hi, cnt_lo} == {mhi_q, mlo_q}))
                         : (inc_hi && (cnt_hi == mhi_q));
        nxt_lo    = cnt_lo;
        nxt_hi    = cnt_hi;
        if (wide) begin
            if (hit_hi) begin
                nxt_lo = '0;
                nxt_hi = '0;
            end else if (inc_lo) begin
                {nxt_hi, nxt_lo} = wide_plus;
            end
        end else begin
            if (hit_lo)      nxt_lo = '0;
            else if (inc_lo) nxt_lo = cnt_lo + HALF_W'(1);
            if (hit_hi)      nxt_hi = '0;
            else if (inc_hi) nxt_hi = cnt_hi + HALF_W'(1);
        end
        cap_lo_en = rise_a;
        cap_hi_en = wide ? rise_a : rise_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q  <= '0;
            mlo_q    <= '0;
            mhi_q    <= '0;
            cnt_lo   <= '0;
            cnt_hi   <= '0;
            cap_lo   <= '0;
            cap_hi   <= '0;
            irq_lo_q <= 1'b0;
            irq_hi_q <= 1'b0;
        end else begin
            if (wr_en && wr_addr == A_PRESC) presc_q <= wr_data[PRE_W-1:0];
            if (wr_en && wr_addr == A_MLO)   mlo_q   <= wr_data;
            if (wr_en && wr_addr == A_MHI)   mhi_q   <= wr_data;
            cnt_lo <= nxt_lo;
            cnt_hi <= nxt_hi;
            if (cap_lo_en) cap_lo <= cnt_lo;
            if (cap_hi_en) cap_hi <= cnt_hi;
            irq_lo_q <= hit_lo | (irq_lo_q & ~(wr_en && wr_addr == A_CTRL && ctrl_w.clr_lo));
            irq_hi_q <= hit_hi | (irq_hi_q & ~(wr_en && wr_addr == A_CTRL && ctrl_w.clr_hi));
        end
    end

    assign irq_lo = irq_lo_q;
    assign irq_hi = irq_hi_q;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:  rd_data[7:0] = {irq_hi_q, irq_lo_q, 3'b000, run_q, mode_q};
            A_PRESC: rd_data[PRE_W-1:0] = presc_q;
            A_MLO:   rd_data = mlo_q;
            A_MHI:   rd_data = mhi_q;
            A_CLO:   rd_data = cnt_lo;
            A_CHI:   rd_data = cnt_hi;
            A_PLO:   rd_data = cap_lo;
            A_PHI:   rd_data = cap_hi;
        endcase
    end

endmodule

// File: rtl/split_timer_chk.sv
module split_timer_chk #(
    parameter int unsigned HALF_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_q,
    input logic [1:0]        mode_q,
    input logic [HALF_W-1:0] cnt_lo,
    input logic [HALF_W-1:0] cnt_hi,
    input logic [HALF_W-1:0] cap_lo,
    input logic [HALF_W-1:0] cap_hi,
    input logic              rise_a,
    input logic              rise_b,
    input logic              irq_lo,
    input logic              irq_hi
);

    // R11: a stopped counter keeps its value
    p_stopped_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> $stable({cnt_hi, cnt_lo}));

    // R3: the low half steps by one or returns to zero
    p_lo_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_lo) |-> (cnt_lo == HALF_W'($past(cnt_lo) + 1'b1) || cnt_lo == '0));

    // R3: a new high flag comes with a zeroed high count
    p_flag_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_hi) |-> (cnt_hi == '0));

    // R8: low capture only after an input-A edge
    p_caplo_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_lo) |-> $past(rise_a));

    // R8: high capture source follows the mode
    p_caphi_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_hi) |-> ($past(mode_q[1]) ? $past(rise_a) : $past(rise_b)));

    // R6: wide modes never raise the low flag
    p_wide_lo_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_lo) |-> !$past(mode_q[1]));

    // R7: the wide event counter only moves after an input-B edge
    p_evt_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable({cnt_hi, cnt_lo}) && $past(mode_q) == 2'd3) |-> $past(rise_b));

endmodule

bind split_timer split_timer_chk #(.HALF_W(HALF_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_q  (run_q),
    .mode_q (mode_q),
    .cnt_lo (cnt_lo),
    .cnt_hi (cnt_hi),
    .cap_lo (cap_lo),
    .cap_hi (cap_hi),
    .rise_a (rise_a),
    .rise_b (rise_b),
    .irq_lo (irq_lo),
    .irq_hi (irq_hi)
);

// File: tb/split_timer_bench.sv
module split_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pin_a = 1'b0;
    logic       pin_b = 1'b0;
    logic       irq_lo, irq_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    split_timer u_split_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .cap_lo_pin (pin_a),
        .cap_hi_pin (pin_b),
        .irq_lo     (irq_lo),
        .irq_hi     (irq_hi)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  pre;
        logic [7:0]  mlo;
        logic [7:0]  mhi;
        logic [15:0] n;
        logic [7:0]  elo;
        logic [7:0]  ehi;
        logic        fl;
        logic        fh;
    } vec_t;

    // mode, prescale, match lo, match hi, edges, expected lo, hi, flag lo, flag hi
    localparam vec_t VECS [7] = '{
        '{2'd0, 8'd0, 8'd4,   8'hFF, 16'd7,   8'd2,   8'd7, 1'b1, 1'b0},
        '{2'd0, 8'd2, 8'hFF,  8'd1,  16'd10,  8'd3,   8'd1, 1'b0, 1'b1},
        '{2'd2, 8'd0, 8'hFF,  8'hFF, 16'd300, 8'h2C,  8'h01, 1'b0, 1'b0},
        '{2'd2, 8'd0, 8'h02,  8'h01, 16'd260, 8'd1,   8'd0, 1'b0, 1'b1},
        '{2'd1, 8'd1, 8'hFF,  8'hFF, 16'd9,   8'd4,   8'd0, 1'b0, 1'b0},
        '{2'd2, 8'd3, 8'hFF,  8'hFF, 16'd20,  8'd5,   8'd0, 1'b0, 1'b0},
        '{2'd3, 8'd0, 8'hFF,  8'hFF, 16'd50,  8'd0,   8'd0, 1'b0, 1'b0}
    };

    task automatic do_reset();
        rst_n = 1'b0;
        pin_a = 1'b0;
        pin_b = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s addr %0d: actual %h expected %h", tag, a, rd_data, exp);
        end
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic pulse(input bit on_a, input bit on_b);
        @(negedge clk);
        if (on_a) pin_a = 1'b1;
        if (on_b) pin_b = 1'b1;
        @(negedge clk);
        pin_a = 1'b0;
        pin_b = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        string tag;
        logic [7:0] held;

        // R1: reset values on every register and both flags
        do_reset();
        for (int a = 0; a < 8; a++) chk_rd(3'(a), 8'h00, "R1 reset");
        chk_bit(irq_lo, 1'b0, "R1 irq_lo");
        chk_bit(irq_hi, 1'b0, "R1 irq_hi");

        // Table walk: R2 prescaling, R3 matching, modes R4 to R7
        for (int i = 0; i < 7; i++) begin
            case (VECS[i].mode)
                2'd0: tag = "R4/R2/R3";
                2'd1: tag = "R5/R2";
                2'd2: tag = "R6/R2/R3";
                default: tag = "R7";
            endcase
            do_reset();
            wr(3'd1, VECS[i].pre);
            wr(3'd2, VECS[i].mlo);
            wr(3'd3, VECS[i].mhi);
            wr(3'd0, {5'b00000, 1'b1, VECS[i].mode});
            repeat (int'(VECS[i].n)) @(posedge clk);
            @(negedge clk);
            chk_rd(3'd4, VECS[i].elo, tag);
            chk_rd(3'd5, VECS[i].ehi, tag);
            chk_bit(irq_lo, VECS[i].fl, tag);
            chk_bit(irq_hi, VECS[i].fh, tag);
        end

        // R7 and R9: wide event counting, one-high one-low pulses, prescaler ignored
        do_reset();
        wr(3'd1, 8'd5);
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'hFF);
        wr(3'd0, 8'h07);
        for (int k = 0; k < 5; k++) pulse(1'b0, 1'b1);
        repeat (4) @(negedge clk);
        chk_rd(3'd4, 8'd5, "R9 short pulses");
        for (int k = 0; k < 253; k++) pulse(1'b0, 1'b1);
        repeat (4) @(negedge clk);
        chk_rd(3'd4, 8'd2, "R7 wide event lo");
        chk_rd(3'd5, 8'd1, "R7 wide event hi");

        // R5: high half counts input-B edges while low half runs on ticks
        do_reset();
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'hFF);
        wr(3'd0, 8'h05);
        for (int k = 0; k < 3; k++) pulse(1'b0, 1'b1);
        repeat (4) @(negedge clk);
        chk_rd(3'd5, 8'd3, "R5 event half");

        // R8: split capture timing; R10: capture reads leave it unchanged
        do_reset();
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'hFF);
        wr(3'd0, 8'h04);
        repeat (10) @(posedge clk);
        @(negedge clk);
        pin_a = 1'b1; pin_b = 1'b1;
        @(negedge clk);
        pin_a = 1'b0; pin_b = 1'b0;
        repeat (5) @(negedge clk);
        chk_rd(3'd6, 8'd12, "R8 capture lo");
        chk_rd(3'd7, 8'd12, "R8 capture hi");
        chk_rd(3'd6, 8'd12, "R10 capture reread");

        // R8: wide capture from input A, input B ignored
        do_reset();
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'hFF);
        wr(3'd0, 8'h06);
        repeat (300) @(posedge clk);
        @(negedge clk);
        pin_a = 1'b1;
        @(negedge clk);
        pin_a = 1'b0;
        repeat (5) @(negedge clk);
        chk_rd(3'd6, 8'h2E, "R8 wide capture lo");
        chk_rd(3'd7, 8'h01, "R8 wide capture hi");
        pulse(1'b0, 1'b1);
        repeat (5) @(negedge clk);
        chk_rd(3'd7, 8'h01, "R8 input B ignored wide");
        chk_rd(3'd6, 8'h2E, "R8 input B ignored wide lo");

        // R10: flag readback and clear; R11: stopped counter holds
        do_reset();
        wr(3'd2, 8'd2);
        wr(3'd3, 8'hFF);
        wr(3'd0, 8'h04);
        repeat (5) @(posedge clk);
        @(negedge clk);
        wr(3'd0, 8'h00);
        chk_rd(3'd0, 8'h40, "R10 ctrl readback");
        rd_addr = 3'd4;
        #1;
        held = rd_data;
        repeat (20) @(negedge clk);
        chk_rd(3'd4, held, "R11 hold while stopped");
        wr(3'd0, 8'h40);
        chk_bit(irq_lo, 1'b0, "R10 flag clear");
        chk_rd(3'd0, 8'h00, "R10 ctrl after clear");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule